// File: doc/BRIEF.md
# Rank Boundary Address Decoder

This block turns a physical request address into a DRAM channel and rank for a two-channel memory controller with four ranks per channel. It keeps the rank boundary bytes and the rank attribute bytes, which are written one byte at a time through a small configuration port. Each boundary byte counts in 32 MiB units and is cumulative within its channel. Each attribute code gives the page size of a rank or marks it as empty.

The block works out from the configuration whether the two channels are populated identically. When they are, it runs in interleaved mode. In that mode channel 0's boundaries cover twice their programmed size, and address bit 6 picks the channel. Otherwise channel 1's ranks are stacked directly above channel 0's total. A request strobe with an address gives a registered result one cycle later: channel, rank, a hit flag and an out-of-range flag. The interleave indication is a live output.

Top module: `rank_decoder`

## Requirements
- R1: Configuration offsets are as follows. Offsets 0 to 3 hold the channel 0 boundaries of ranks 0 to 3, and offsets 4 to 7 hold the channel 1 boundaries. Offsets 8 and 9 hold the channel 0 attribute bytes for rank pairs 0/1 and 2/3, and offsets 10 and 11 hold the same pairs for channel 1. Writes to offsets 12 to 15 change nothing. Reset clears every byte to zero.
- R2: In an attribute byte, bits 2:0 give the code of the even rank and bits 6:4 give the code of the odd rank. Only codes 010, 011 and 100 mark a populated rank. Code 000 and every other code make the rank empty, whatever its boundary.
- R3: A rank whose boundary equals the boundary of the previous rank in the same channel is empty. Rank 0 is compared against zero.
- R4: `interleaved` is 1 exactly when both channels have equal attribute codes (bits 7 and 3 ignored) and equal boundaries for all four ranks. It reflects a write from the cycle after that write. Just after reset it reads 1.
- R5: In interleaved mode only channel 0's ranks are searched, each with an effective boundary of twice its value. The reported channel is address bit 6.
- R6: In non-interleaved mode, the effective boundary of a channel 0 rank is its value. The effective boundary of a channel 1 rank is the channel 0 rank 3 boundary plus its own value. The channel reported is the channel of the selected rank.
- R7: The selected rank is the lowest-index populated rank whose effective boundary is greater than address bits 33:25. Ranks are ordered channel 0 ranks 0 to 3, then channel 1 ranks 0 to 3.
- R8: When no rank qualifies, the result has the out-of-range flag at 1, the hit flag at 0, and channel and rank at 0.
- R9: The result appears one cycle after the strobe with `rsp_valid` set. In a cycle after no strobe, `rsp_valid`, the hit flag, the out-of-range flag, the channel and the rank are all 0.
- R10: A request strobed in the same cycle as a configuration write is decoded with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| req_valid | input | 1 | Request address strobe |
| req_addr | input | 34 | Request physical address |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_chan | output | 1 | Decoded channel |
| rsp_rank | output | 2 | Decoded rank within the channel |
| rsp_hit | output | 1 | Address falls in a populated rank |
| rsp_oor | output | 1 | Address matches no populated rank |
| interleaved | output | 1 | Channels are populated identically |

## Verification
A configuration write and a decode can land in the same cycle. If the write changes a boundary, an attribute or the interleave condition, the decode could use either configuration. The bench strobes requests while it rewrites channel 1 bytes, including the write that breaks interleaving. It expects each result from the reference model's configuration as it stood before that write, and expects `interleaved` to change only in the following cycle.

// File: rtl/rank_decoder.sv
module rank_decoder #(
  parameter int AW         = 34,
  parameter int UNIT_SHIFT = 25,
  parameter int BW         = 8,
  parameter int RANKS      = 4,
  parameter int CH_BIT     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_chan,
  output logic [1:0]    rsp_rank,
  output logic          rsp_hit,
  output logic          rsp_oor,
  output logic          interleaved
);
  localparam int NR  = 2 * RANKS;
  localparam int NA  = RANKS;
  localparam int UW  = AW - UNIT_SHIFT;
  localparam int RW  = $clog2(RANKS);
  localparam int IW  = RW + 1;

  logic [BW-1:0] bnd [NR];
  logic [7:0]    atr [NA];
  logic [UW-1:0] unit;
  logic [NR-1:0] pop, cand;
  logic [IW-1:0] sel;
  logic          any;
  logic          unused_bits;

  assign unit        = req_addr[AW-1:UNIT_SHIFT];
  assign unused_bits = ^req_addr[UNIT_SHIFT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) bnd[i] <= '0;
      for (int i = 0; i < NA; i++) atr[i] <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NR; i++)
        if (cfg_addr == 4'(i)) bnd[i] <= cfg_wdata[BW-1:0];
      for (int i = 0; i < NA; i++)
        if (cfg_addr == 4'(NR + i)) atr[i] <= cfg_wdata;
    end
  end

  always_comb begin
    interleaved = 1'b1;
    for (int r = 0; r < RANKS; r++)
      if (bnd[r] != bnd[RANKS + r]) interleaved = 1'b0;
    for (int a = 0; a < NA / 2; a++)
      if ((atr[a] & 8'h77) != (atr[NA / 2 + a] & 8'h77)) interleaved = 1'b0;
  end

  for (genvar g = 0; g < NR; g++) begin : g_rank
    localparam int C = g / RANKS;
    localparam int R = g % RANKS;
    logic [7:0]    ab;
    logic [2:0]    code;
    logic [BW-1:0] prev;
    logic [UW-1:0] eff;
    assign ab = atr[C * (NA / 2) + R / 2];
    if (R % 2 == 1) begin : g_odd
      assign code = ab[6:4];
    end else begin : g_even
      assign code = ab[2:0];
    end
    if (R == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = bnd[g-1];
    end
    if (C == 0) begin : g_ch0
      assign eff = interleaved ? UW'({bnd[g], 1'b0}) : UW'(bnd[g]);
    end else begin : g_ch1
      assign eff = UW'(bnd[RANKS-1]) + UW'(bnd[g]);
    end
    assign pop[g]  = (code == 3'd2 || code == 3'd3 || code == 3'd4) && (bnd[g] != prev);
    assign cand[g] = pop[g] && (eff > unit) && (C == 0 || !interleaved);
  end

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NR - 1; i >= 0; i--)
      if (cand[i]) begin
        any = 1'b1;
        sel = IW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_oor   <= 1'b0;
      rsp_chan  <= 1'b0;
      rsp_rank  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any;
      rsp_oor   <= req_valid && !any;
      rsp_chan  <= req_valid && any && (interleaved ? req_addr[CH_BIT] : sel[RW]);
      rsp_rank  <= (req_valid && any) ? 2'(sel[RW-1:0]) : '0;
    end
  end

  // R9
  rsp_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_oor && !rsp_chan && rsp_rank == '0));

  // R8
  hit_xor_oor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_oor}) == 1);

  // R8
  oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_oor |-> (!rsp_chan && rsp_rank == '0));

  // R5
  ilv_chan_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && $past(interleaved)) |-> rsp_chan == $past(req_addr[CH_BIT]));

  // R2 R3
  hit_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (($past(pop) >> {rsp_chan && !$past(interleaved), RW'(rsp_rank)}) & NR'(1)) != '0);
endmodule

// File: tb/test_rank_decoder.sv
module test_rank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [33:0] req_addr = '0;
  logic        rsp_valid, rsp_chan, rsp_hit, rsp_oor, interleaved;
  logic [1:0]  rsp_rank;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int m_bnd [8];
  int m_atr [4];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  rank_decoder i_rank_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_chan(rsp_chan),
    .rsp_rank(rsp_rank), .rsp_hit(rsp_hit), .rsp_oor(rsp_oor), .interleaved(interleaved)
  );

  function automatic int rnd(int n);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % n);
  endfunction

  function automatic int m_code(int i);
    int b = m_atr[(i / 4) * 2 + (i % 4) / 2];
    return (i % 2) ? ((b >> 4) & 7) : (b & 7);
  endfunction

  function automatic bit m_pop(int i);
    int prev = (i % 4 == 0) ? 0 : m_bnd[i-1];
    int c = m_code(i);
    return (c >= 2 && c <= 4) && m_bnd[i] != prev;
  endfunction

  function automatic bit m_ilv();
    for (int r = 0; r < 4; r++)
      if (m_bnd[r] != m_bnd[r+4] || m_code(r) != m_code(r+4)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic void ref_decode(input logic [33:0] a, output bit h, output bit c, output int r);
    int u = int'(a[33:25]);
    bit il = m_ilv();
    h = 0; c = 0; r = 0;
    for (int i = 0; i < 8; i++) begin
      int e;
      if (il && i >= 4) break;
      e = (i < 4) ? (il ? 2 * m_bnd[i] : m_bnd[i]) : m_bnd[3] + m_bnd[i];
      if (m_pop(i) && e > u) begin
        h = 1; c = il ? a[6] : (i >= 4); r = i % 4;
        break;
      end
    end
  endfunction

  task automatic cyc(input bit we, input int ca, input int cd, input bit v, input logic [33:0] a,
                     input string tag);
    bit eh, ec; int er; bit ev, eo, ei;
    cfg_we = we; cfg_addr = 4'(ca); cfg_wdata = 8'(cd); req_valid = v; req_addr = a;
    ref_decode(a, eh, ec, er);
    ev = v; eo = v && !eh;
    if (!v) begin eh = 0; ec = 0; er = 0; end
    if (we) begin
      if (ca < 8) m_bnd[ca] = cd;
      else if (ca < 12) m_atr[ca-8] = cd;
    end
    ei = m_ilv();
    @(negedge clk);
    n_run++;
    if (rsp_valid !== ev || rsp_hit !== eh || rsp_oor !== eo || rsp_chan !== ec ||
        int'(rsp_rank) !== er || interleaved !== ei) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b hit=%0b oor=%0b ch=%0b rank=%0d ilv=%0b expected v=%0b hit=%0b oor=%0b ch=%0b rank=%0d ilv=%0b",
               tag, rsp_valid, rsp_hit, rsp_oor, rsp_chan, rsp_rank, interleaved,
               ev, eh, eo, ec, er, ei);
    end
    cfg_we = 0; req_valid = 0;
  endtask

  function automatic logic [33:0] mk(int u, bit b6);
    logic [33:0] a = {9'(u), 25'(rnd(1 << 24))};
    a[6] = b6;
    return a;
  endfunction

  task automatic sweep(int top, string tag);
    for (int u = 0; u <= top; u++) cyc(0, 0, 0, 1, mk(u, u[0] ^ u[2]), tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_bnd[i] = 0;
    for (int i = 0; i < 4; i++) m_atr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R4 R9: reset state, all zero config reads as interleaved
    cyc(0, 0, 0, 0, '0, "R1 R4 R9 reset");
    // R8: nothing populated
    cyc(0, 0, 0, 1, mk(0, 0), "R8 empty config");
    // R1 R2 R3 R6: non-interleaved population
    cyc(1, 8, 8'h32, 0, '0, "R1 R2 cfg");
    cyc(1, 9, 8'h04, 0, '0, "R1 R2 cfg");
    cyc(1, 10, 8'h22, 0, '0, "R1 R2 cfg");
    cyc(1, 11, 8'h22, 0, '0, "R1 R2 cfg");
    cyc(1, 0, 4, 0, '0, "R1 cfg");
    cyc(1, 1, 12, 0, '0, "R1 cfg");
    cyc(1, 2, 12, 0, '0, "R1 cfg");
    cyc(1, 3, 20, 0, '0, "R1 cfg");
    cyc(1, 4, 8, 0, '0, "R1 cfg");
    cyc(1, 5, 8, 0, '0, "R1 cfg");
    cyc(1, 6, 16, 0, '0, "R1 cfg");
    cyc(1, 7, 16, 0, '0, "R1 cfg");
    // R3 R6 R7 R8: units 12..19 skip empty ch0 ranks into ch1 rank 0; 36 and up out of range
    sweep(40, "R3 R6 R7 R8 stacked");
    cyc(0, 0, 0, 0, '0, "R9 idle");
    // R2: reserved code 7 on ch1 rank 3, code 0 on rank 2
    cyc(1, 11, 8'h70, 0, '0, "R2 reserved code");
    cyc(1, 7, 30, 0, '0, "R2 cfg");
    sweep(50, "R2 reserved empty");
    // R1: writes to unused offsets leave the decode unchanged
    for (int k = 12; k < 16; k++) cyc(1, k, 8'hFF, 0, '0, "R1 unused offset");
    sweep(50, "R1 unused offsets ignored");
    // R4 R5: identical population with differing reserved bits
    cyc(1, 4, 4, 0, '0, "R4 cfg");
    cyc(1, 5, 12, 0, '0, "R4 cfg");
    cyc(1, 6, 12, 0, '0, "R4 cfg");
    cyc(1, 7, 20, 0, '0, "R4 cfg");
    cyc(1, 10, 8'hBA, 0, '0, "R4 reserved bits");
    cyc(1, 11, 8'h8C, 0, '0, "R4 reserved bits");
    cyc(1, 11, 8'h84, 0, '0, "R4 interleaved on");
    sweep(44, "R5 interleaved");
    for (int u = 0; u < 10; u++) cyc(0, 0, 0, 1, mk(u, 1), "R5 chan bit 6");
    // R10: write and strobe collide; decode uses pre-write config
    cyc(1, 4, 6, 1, mk(9, 1), "R10 collide ilv break");
    cyc(0, 0, 0, 1, mk(9, 1), "R10 after write");
    cyc(1, 4, 4, 1, mk(25, 0), "R10 collide ilv restore");
    cyc(1, 0, 30, 1, mk(5, 1), "R10 collide bnd");
    cyc(0, 0, 0, 1, mk(5, 1), "R10 after bnd");
    // R2 R3 R5 R6 R7: pseudo-random configurations
    for (int round = 0; round < 24; round++) begin
      int acc;
      int codes [8] = '{0, 2, 3, 4, 2, 3, 4, 7};
      acc = 0;
      for (int r = 0; r < 4; r++) begin
        acc += rnd(3) == 0 ? 0 : rnd(40);
        if (acc > 255) acc = 255;
        cyc(1, r, acc, 0, '0, "R7 rnd cfg");
      end
      for (int p = 0; p < 2; p++)
        cyc(1, 8 + p, codes[rnd(8)] | (codes[rnd(8)] << 4) | (rnd(2) << 7), 0, '0, "R2 rnd cfg");
      acc = 0;
      for (int r = 0; r < 4; r++) begin
        acc += rnd(3) == 0 ? 0 : rnd(40);
        if (acc > 255) acc = 255;
        cyc(1, 4 + r, (round % 2) ? m_bnd[r] : acc, 0, '0, "R7 rnd cfg");
      end
      for (int p = 0; p < 2; p++)
        cyc(1, 10 + p, (round % 2) ? (m_atr[p] ^ 8'h08) : codes[rnd(8)] | (codes[rnd(8)] << 4),
            0, '0, "R4 rnd cfg");
      for (int k = 0; k < 40; k++) cyc(0, 0, 0, rnd(5) != 0, mk(rnd(330), rnd(2)), "R5 R6 R7 rnd");
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule